// File: doc/BRIEF.md
# Self-Recovering Maximal-Length Pseudo-Random Generator

This block is an N-bit feedback shift register that steps through every nonzero state in a fixed pseudo-random order, one step per enabled clock. A purely linear register of this kind has a trap: if it ever holds all zeros, every later state is zero too and the serial output stays low forever. Here that trap cannot last. A bit flip could cause it, and so could a deliberate overwrite. A small counter watches the serial output bit and counts how many zeros in a row have come out. A one clears it.

The longest run of zeros that a maximal-length sequence can produce is one shorter than the register width. So the Nth consecutive zero can only come from the stuck all-zero state. On that step the block ORs a one into the feedback bit for a single cycle, which brings the register back to the reset seed, and it raises a one-cycle recovery pulse. While the register stays in its normal cycle the extra term is always zero, so the sequence is exactly the linear one. A force port overwrites the state, so that a fault can be injected.

Top module: `lockup_safe_lfsr`

## Requirements
- R1: While `rst` is high at a clock edge, the state is set to the seed (only bit 0 set, value 1), and the run count is cleared. Just after reset, `dout` is 0 and `recover_pulse` is 0.
- R2: On an edge with `en` high and `force_en` low, the state becomes {state[W-2:0], fb}. Here fb is the XOR of the state bits whose positions are set in `TAP_MASK` (default W=8, mask 8'hB8), and `dout` always equals state bit W-1.
- R3: On an edge with both `en` and `force_en` low, the state does not change and `recover_pulse` stays 0.
- R4: On an edge with `force_en` high, the state takes `force_val` whatever `en` is, and the consecutive-zero count is cleared.
- R5: From the seed, the state comes back to the seed after exactly 2^W-1 enabled steps and not earlier. It is never zero on the way, and `recover_pulse` stays 0 throughout.
- R6: Once the state has been forced to all zeros, it stays zero for W-1 enabled steps. On the Wth enabled step it becomes the seed (value 1), and in that same cycle `recover_pulse` reads 1.
- R7: `recover_pulse` is high for exactly one cycle for each recovery.
- R8: Cycles with `en` low do not count toward the zero run. Recovery still takes exactly W enabled steps when enabled steps are mixed with idle ones.
- R9: After a recovery, the state follows the R2 stepping rule again, with no further pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the register one step |
| force_en | input | 1 | Overwrite the state this edge (has priority over en) |
| force_val | input | WIDTH | Value loaded when force_en is high |
| dout | output | 1 | Serial output, state bit WIDTH-1 |
| state_q | output | WIDTH | Parallel register state |
| recover_pulse | output | 1 | One-cycle flag after a lockup recovery |

## Verification
The assertions assume that the all-zero state is reached only through the force port, or is already being recovered from. They also assume that `force_en` is never held for several cycles while the bound on time spent at zero is being measured. In the bench, each force lasts a single cycle, and every zero injection is followed by enabled or idle steps with `force_en` low. Each forced nonzero value is a member of the maximal-length cycle, because every nonzero W-bit value is, so the no-trigger property holds in every scenario.

// File: rtl/lockup_safe_lfsr_pkg.sv
package lockup_safe_lfsr_pkg;

    // Widest register the helpers below support.
    localparam int unsigned MAX_W = 64;

    // What the state register does on a given edge.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_SHIFT = 2'd1,
        ACT_LOAD  = 2'd2
    } lfsr_act_e;

    // Per-cycle handshake between the run counter and the register.
    typedef struct packed {
        logic step;    // an enabled shift happens this edge
        logic clear;   // the run history is discarded (forced load)
    } run_ctrl_t;

    // Parity of the tapped bits.
    function automatic logic tap_parity(input logic [MAX_W-1:0] s,
                                        input logic [MAX_W-1:0] m);
        return ^(s & m);
    endfunction

endpackage

// File: rtl/lockup_safe_lfsr_ctrl.sv
module lockup_safe_lfsr_ctrl
    import lockup_safe_lfsr_pkg::*;
(
    input  logic      en,
    input  logic      force_en,
    output lfsr_act_e act,
    output run_ctrl_t rc
);
    always_comb begin
        if (force_en) begin
            act = ACT_LOAD;
        end else if (en) begin
            act = ACT_SHIFT;
        end else begin
            act = ACT_HOLD;
        end
        rc.step  = (act == ACT_SHIFT);
        rc.clear = (act == ACT_LOAD);
    end
endmodule

// File: rtl/lockup_safe_lfsr_runcnt.sv
module lockup_safe_lfsr_runcnt
    import lockup_safe_lfsr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  run_ctrl_t rc,
    input  logic      bit_out,
    output logic      inject,
    output logic      pulse_q
);
    // The count never has to exceed WIDTH-1.
    localparam int unsigned CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LIMIT = CW'(WIDTH - 1);

    logic [CW-1:0] run_q;

    // The Wth zero in a row can only come from the all-zero state.
    assign inject = rc.step && !bit_out && (run_q == LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= inject;
            if (rc.clear) begin
                run_q <= '0;
            end else if (rc.step) begin
                if (bit_out || inject) begin
                    run_q <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lockup_safe_lfsr_shreg.sv
module lockup_safe_lfsr_shreg
    import lockup_safe_lfsr_pkg::*;
#(
    parameter int unsigned     WIDTH    = 8,
    parameter logic [WIDTH-1:0] TAP_MASK = 8'hB8
) (
    input  logic             clk,
    input  logic             rst,
    input  lfsr_act_e        act,
    input  logic             inject,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] state_q
);
    localparam logic [WIDTH-1:0] SEED = WIDTH'(1);

    logic fb_lin;
    logic fb;

    assign fb_lin = tap_parity(MAX_W'(state_q), MAX_W'(TAP_MASK));
    // The injected one only matters when the linear feedback is zero from an all-zero state.
    assign fb     = fb_lin | inject;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else begin
            case (act)
                ACT_LOAD:  state_q <= load_val;
                ACT_SHIFT: state_q <= {state_q[WIDTH-2:0], fb};
                default:   state_q <= state_q;
            endcase
        end
    end
endmodule

// File: rtl/lockup_safe_lfsr.sv
module lockup_safe_lfsr
    import lockup_safe_lfsr_pkg::*;
#(
    parameter int unsigned      WIDTH    = 8,
    parameter logic [WIDTH-1:0] TAP_MASK = 8'hB8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             force_en,
    input  logic [WIDTH-1:0] force_val,
    output logic             dout,
    output logic [WIDTH-1:0] state_q,
    output logic             recover_pulse
);
    lfsr_act_e act;
    run_ctrl_t rc;
    logic      inject;

    lockup_safe_lfsr_ctrl u_ctrl (
        .en       (en),
        .force_en (force_en),
        .act      (act),
        .rc       (rc)
    );

    lockup_safe_lfsr_shreg #(
        .WIDTH    (WIDTH),
        .TAP_MASK (TAP_MASK)
    ) u_shreg (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .inject   (inject),
        .load_val (force_val),
        .state_q  (state_q)
    );

    assign dout = state_q[WIDTH-1];

    lockup_safe_lfsr_runcnt #(
        .WIDTH (WIDTH)
    ) u_runcnt (
        .clk     (clk),
        .rst     (rst),
        .rc      (rc),
        .bit_out (dout),
        .inject  (inject),
        .pulse_q (recover_pulse)
    );
endmodule

// File: rtl/lockup_safe_lfsr_chk.sv
module lockup_safe_lfsr_chk #(
    parameter int unsigned      WIDTH    = 8,
    parameter logic [WIDTH-1:0] TAP_MASK = 8'hB8
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             force_en,
    input logic [WIDTH-1:0] force_val,
    input logic             dout,
    input logic [WIDTH-1:0] state_q,
    input logic             recover_pulse
);
    localparam int unsigned ZW = $clog2(WIDTH + 1) + 1;

    // Enabled steps spent in the all-zero state, counted independently of the design.
    logic [ZW-1:0] zdwell;
    logic          shift_edge;

    assign shift_edge = en && !force_en;

    always_ff @(posedge clk) begin
        if (rst || force_en) begin
            zdwell <= '0;
        end else if (state_q != '0) begin
            zdwell <= '0;
        end else if (shift_edge && zdwell < ZW'(WIDTH + 1)) begin
            zdwell <= zdwell + 1'b1;
        end
    end

    AST_SEED_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_q == WIDTH'(1) && !recover_pulse)); // R1

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (shift_edge && state_q != '0) |=>
            state_q == {$past(state_q[WIDTH-2:0]), ^($past(state_q) & TAP_MASK)}); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!en && !force_en) |=> ($stable(state_q) && !recover_pulse)); // R3

    AST_FORCE_LOAD: assert property (@(posedge clk) disable iff (rst)
        force_en |=> state_q == $past(force_val)); // R4

    AST_PULSE_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        recover_pulse |-> ($past(state_q) == '0 && state_q == WIDTH'(1))); // R6

    AST_ZERO_DWELL_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state_q == '0) |-> (zdwell < ZW'(WIDTH))); // R6

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        recover_pulse |=> !recover_pulse); // R7

    AST_SERIAL_MSB: assert property (@(posedge clk) disable iff (rst)
        dout == state_q[WIDTH-1]); // R2
endmodule

bind lockup_safe_lfsr lockup_safe_lfsr_chk #(
    .WIDTH    (WIDTH),
    .TAP_MASK (TAP_MASK)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .en            (en),
    .force_en      (force_en),
    .force_val     (force_val),
    .dout          (dout),
    .state_q       (state_q),
    .recover_pulse (recover_pulse)
);

// File: tb/test_lockup_safe_lfsr.sv
`timescale 1ns/100ps
module test_lockup_safe_lfsr;
    localparam int unsigned W    = 8;
    localparam logic [W-1:0] MASK = 8'hB8;

    logic         clk = 1'b0;
    logic         rst;
    logic         en;
    logic         force_en;
    logic [W-1:0] force_val;
    logic         dout;
    logic [W-1:0] state_q;
    logic         recover_pulse;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lockup_safe_lfsr #(.WIDTH(W), .TAP_MASK(MASK)) i_lockup_safe_lfsr (
        .clk (clk), .rst (rst), .en (en), .force_en (force_en),
        .force_val (force_val), .dout (dout), .state_q (state_q),
        .recover_pulse (recover_pulse)
    );

    // Stepping rule from R2.
    function automatic logic [W-1:0] nxt(input logic [W-1:0] s);
        return {s[W-2:0], ^(s & MASK)};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1; en = 1'b0; force_en = 1'b0; force_val = '0;
        repeat (3) tick();
        rst = 1'b0;
        check("R1 seed", state_q, 1);
        check("R1 dout", dout, 0);
        check("R1 pulse", recover_pulse, 0);
    endtask

    task automatic t_full_period();
        logic [W-1:0] exp = 1;
        int early = 0, zero_seen = 0, pulses = 0, mism = 0;
        en = 1'b1;
        for (int i = 1; i <= 255; i++) begin
            tick();
            exp = nxt(exp);
            if (state_q !== exp) mism++;
            if (dout !== state_q[W-1]) mism++;
            if (state_q == 1 && i < 255) early++;
            if (state_q == 0) zero_seen++;
            if (recover_pulse) pulses++;
        end
        en = 1'b0;
        check("R2 stepping mismatches", mism, 0);
        check("R5 back at seed", state_q, 1);
        check("R5 early return", early, 0);
        check("R5 zero seen", zero_seen, 0);
        check("R5 pulses in period", pulses, 0);
    endtask

    task automatic t_idle_hold();
        logic [W-1:0] s;
        en = 1'b1; repeat (5) tick();
        en = 1'b0; s = state_q;
        repeat (4) tick();
        check("R3 hold state", state_q, s);
        check("R3 no pulse", recover_pulse, 0);
    endtask

    task automatic t_force_value();
        logic [W-1:0] exp;
        int mism = 0;
        en = 1'b1; force_en = 1'b1; force_val = 8'h5A;
        tick();
        force_en = 1'b0;
        check("R4 load with en high", state_q, 8'h5A);
        exp = 8'h5A;
        for (int i = 0; i < 20; i++) begin
            tick(); exp = nxt(exp);
            if (state_q !== exp || recover_pulse) mism++;
        end
        en = 1'b0;
        check("R2 after load", mism, 0);
    endtask

    task automatic t_force_clears_run();
        // W-1 zeros seen, then a forced seed: its own W-1 zeros must not trigger.
        force_en = 1'b1; force_val = '0; tick();
        force_en = 1'b0; en = 1'b1;
        repeat (W - 1) tick();
        en = 1'b0; force_en = 1'b1; force_val = 8'h01; tick();
        force_en = 1'b0; en = 1'b1; tick(); en = 1'b0;
        check("R4 run cleared state", state_q, 8'h02);
        check("R4 run cleared pulse", recover_pulse, 0);
    endtask

    task automatic t_recover();
        logic [W-1:0] exp;
        int mism = 0, pulses = 0;
        force_en = 1'b1; force_val = '0; en = 1'b0; tick();
        force_en = 1'b0;
        check("R4 zero load", state_q, 0);
        check("R2 dout zero", dout, 0);
        en = 1'b1;
        for (int k = 1; k <= W; k++) begin
            tick();
            if (k < W) begin
                if (state_q !== 0 || recover_pulse !== 0) mism++;
            end
        end
        check("R6 early change", mism, 0);
        check("R6 reseed", state_q, 1);
        check("R6 pulse", recover_pulse, 1);
        tick();
        check("R7 pulse one cycle", recover_pulse, 0);
        check("R9 first step", state_q, 2);
        exp = 2; mism = 0;
        for (int i = 0; i < 300; i++) begin
            tick(); exp = nxt(exp);
            if (state_q !== exp) mism++;
            if (recover_pulse) pulses++;
        end
        en = 1'b0;
        check("R9 resumed mismatches", mism, 0);
        check("R9 extra pulses", pulses, 0);
    endtask

    task automatic t_recover_gaps();
        int steps = 0, hit_at = -1, pulses = 0;
        force_en = 1'b1; force_val = '0; tick();
        force_en = 1'b0;
        for (int c = 0; c < 4 * W; c++) begin
            en = (c % 3 != 1);
            tick();
            if (en) steps++;
            if (recover_pulse) begin
                pulses++;
                if (hit_at < 0) hit_at = steps;
            end
        end
        en = 1'b0;
        check("R8 enabled steps to recover", hit_at, W);
        check("R7 single pulse", pulses, 1);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_full_period();
        t_idle_hold();
        t_force_value();
        t_force_clears_run();
        t_recover();
        t_recover_gaps();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule